// File: doc/BRIEF.md
# GPIO Port Control Register File

This block holds the control state of one eight-pin general-purpose I/O port and exposes it on a simple word-addressed bus. Three writable registers set the pin state: a per-pin mode bit that selects GPIO or the alternate function, a per-pin drive-enable, and a per-pin drive level. A fourth, read-only register returns the pad inputs after a two-flop synchronizer. The pads take the drive-enable and drive level directly from the registers. The mode bits and the synchronized inputs also go out as ports, so that neighbouring interrupt and debounce logic can use them.

Each writable register can be reached at two addresses. At the plain address a write replaces all eight bits. At the masked address the upper byte of the write data is a per-bit write strobe for the lower byte. Software can therefore set or clear a single pin in one bus cycle, with no read-modify-write and no lock between agents. Register groups are 0x10 apart (mode 0x00, drive-enable 0x10, drive level 0x20, pad input 0x30). The masked aliases repeat this layout at `MASK_OFS` (default 0x80). Within each group this port owns the word at `PORT_IDX*4` (default slot 2).

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the mode, drive-enable and drive-level registers are zero, `pad_oe`, `pad_out`, `pin_mode` and `bus_rvalid` are 0, and `bus_rdata` is 0.
- R2: A plain write to group offset + `PORT_IDX*4` (mode 0x00, drive-enable 0x10, drive level 0x20) loads `bus_wdata[7:0]` into that register at the clock edge. `bus_wdata[15:8]` is ignored.
- R3: A write to the masked alias (`MASK_OFS` + the same group offset) updates bit n from `bus_wdata[n]` only where `bus_wdata[8+n]` is 1. All other bits keep their value, and a zero strobe byte leaves the register unchanged.
- R4: `pad_oe` and `pad_out` equal the drive-enable and drive-level registers, so each pin with drive-enable 1 drives its level bit. Both change in the cycle after the write edge.
- R5: A read request gives `bus_rvalid`=1 with data on the next cycle. `bus_rdata[7:0]` holds the register value, `bus_rdata[15:8]` is zero, and the plain and masked addresses of a register return the same value. In cycles with no read, `bus_rvalid` and `bus_rdata` are 0.
- R6: The pad-input register (group offset 0x30) reads the synchronized pad value, and writes to it change nothing.
- R7: An access to any other address has no effect and reads 0. This covers another port's slot, a word offset with bits [1:0] nonzero, offsets at or above 0x40 in either window, and the masked pad-input alias. No state changes in a cycle without a write.
- R8: `pin_in_sync` equals `pad_in` as sampled two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 2*PINS | Write data; upper half is the per-bit strobe on masked aliases |
| bus_rdata | output | 2*PINS | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | PINS | Asynchronous pad inputs |
| pad_out | output | PINS | Drive level to pads |
| pad_oe | output | PINS | Drive enable to pads |
| pin_mode | output | PINS | Per-pin GPIO (1) / alternate function (0) select |
| pin_in_sync | output | PINS | Synchronized pad inputs |

## Verification
The properties assume that reset is held for at least two cycles, so that the synchronizer history they compare against is defined, and that the bus request, write flag and address are known at every clock edge. The stimulus drives all inputs on the falling edge, starts with four reset cycles, and then mixes directed pin updates with random accesses. The random accesses use an address pool that includes foreign slots, unaligned offsets and the masked pad alias, together with random strobe bytes and a pad input that changes every cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // register groups inside one address window, in address order
    typedef enum logic [1:0] {
        GRP_MODE  = 2'd0,
        GRP_DIR   = 2'd1,
        GRP_LEVEL = 2'd2,
        GRP_PAD   = 2'd3
    } grp_e;

    // result of decoding one bus address
    typedef struct packed {
        logic hit;      // address belongs to this port and is mapped
        logic masked;   // access through the strobed alias window
        grp_e grp;      // register group
    } acc_s;

    localparam int unsigned GRP_STRIDE  = 16;
    localparam int unsigned SLOT_STRIDE = 4;
    localparam int unsigned NUM_GRPS    = 4;
    localparam int unsigned CTRL_REGS   = 3;   // writable groups
    localparam int unsigned GRP_LSB     = $clog2(GRP_STRIDE);
    localparam int unsigned SLOT_LSB    = $clog2(SLOT_STRIDE);
    localparam int unsigned WIN_LSB     = GRP_LSB + $clog2(NUM_GRPS);

    function automatic logic is_ctrl(grp_e g);
        return g != GRP_PAD;
    endfunction

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned MASK_OFS = 'h80,
    parameter int unsigned PORT_IDX = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_s              acc
);
    localparam int unsigned SLOT_W = GRP_LSB - SLOT_LSB;

    logic [ADDR_W-1:0] mask_rel;
    logic [ADDR_W-1:0] rel;
    logic              in_plain;
    logic              in_mask;
    logic              slot_ok;

    always_comb begin
        mask_rel = addr - ADDR_W'(MASK_OFS);
        in_plain = (addr[ADDR_W-1:WIN_LSB] == '0);
        in_mask  = (addr >= ADDR_W'(MASK_OFS)) && (mask_rel[ADDR_W-1:WIN_LSB] == '0);
        rel      = in_mask ? mask_rel : addr;
        slot_ok  = (rel[GRP_LSB-1:SLOT_LSB] == SLOT_W'(PORT_IDX)) &&
                   (rel[SLOT_LSB-1:0] == '0);

        acc.grp    = grp_e'(rel[WIN_LSB-1:GRP_LSB]);
        acc.masked = in_mask;
        // the strobed window has no pad-input alias
        acc.hit    = (in_plain || in_mask) && slot_ok &&
                     !(in_mask && !is_ctrl(acc.grp));
    end

endmodule

// File: rtl/gpio_port_ctrl_reg.sv
module gpio_port_ctrl_reg #(
    parameter int unsigned PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_plain,
    input  logic              wr_mask,
    input  logic [2*PINS-1:0] wdata,
    output logic [PINS-1:0]   q
);
    logic [PINS-1:0] strobe;
    logic [PINS-1:0] value;
    logic [PINS-1:0] merged;

    assign value  = wdata[PINS-1:0];
    assign strobe = wdata[2*PINS-1:PINS];

    // per-pin merge: strobed bits take new data, others keep state
    for (genvar b = 0; b < PINS; b++) begin : g_bit
        assign merged[b] = strobe[b] ? value[b] : q[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_plain) begin
            q <= value;
        end else if (wr_mask) begin
            q <= merged;
        end
    end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int unsigned PINS   = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] sync_q
);
    // synchronizer flops carry no reset: they flush within STAGES cycles
    logic [PINS-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= pad_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS        = 8,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned MASK_OFS    = 'h80,
    parameter int unsigned PORT_IDX    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2*PINS-1:0] bus_wdata,
    output logic [2*PINS-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pin_mode,
    output logic [PINS-1:0]   pin_in_sync
);
    acc_s            acc;
    logic            wr_cyc;
    logic            rd_cyc;
    logic [PINS-1:0] ctrl_q [CTRL_REGS];
    logic [PINS-1:0] sync_q;
    logic [PINS-1:0] rd_val;

    assign wr_cyc = bus_req && bus_we;
    assign rd_cyc = bus_req && !bus_we;

    gpio_port_decode #(
        .ADDR_W  (ADDR_W),
        .MASK_OFS(MASK_OFS),
        .PORT_IDX(PORT_IDX)
    ) u_decode (
        .addr(bus_addr),
        .acc (acc)
    );

    for (genvar g = 0; g < CTRL_REGS; g++) begin : g_ctrl
        logic sel;
        assign sel = wr_cyc && acc.hit && (acc.grp == grp_e'(2'(g)));

        gpio_port_ctrl_reg #(.PINS(PINS)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_plain(sel && !acc.masked),
            .wr_mask (sel && acc.masked),
            .wdata   (bus_wdata),
            .q       (ctrl_q[g])
        );
    end

    gpio_port_sync #(
        .PINS  (PINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .pad_in(pad_in),
        .sync_q(sync_q)
    );

    always_comb begin
        rd_val = '0;
        if (acc.hit) begin
            unique case (acc.grp)
                GRP_MODE:  rd_val = ctrl_q[GRP_MODE];
                GRP_DIR:   rd_val = ctrl_q[GRP_DIR];
                GRP_LEVEL: rd_val = ctrl_q[GRP_LEVEL];
                GRP_PAD:   rd_val = sync_q;
                default:   rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_cyc;
            bus_rdata  <= rd_cyc ? {{PINS{1'b0}}, rd_val} : '0;
        end
    end

    assign pin_mode    = ctrl_q[GRP_MODE];
    assign pad_oe      = ctrl_q[GRP_DIR];
    assign pad_out     = ctrl_q[GRP_LEVEL];
    assign pin_in_sync = sync_q;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int unsigned PINS        = 8,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned MASK_OFS    = 'h80,
    parameter int unsigned PORT_IDX    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2*PINS-1:0] bus_wdata,
    input logic [2*PINS-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic [PINS-1:0]   pad_in,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pin_mode,
    input logic [PINS-1:0]   pin_in_sync
);
    localparam logic [ADDR_W-1:0] DIR_PLAIN  = ADDR_W'('h10 + PORT_IDX * 4);
    localparam logic [ADDR_W-1:0] LEVEL_MASK = ADDR_W'(MASK_OFS + 'h20 + PORT_IDX * 4);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && pad_out == '0 && pin_mode == '0 && !bus_rvalid)); // R1

    AST_DIR_PLAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == DIR_PLAIN) |=> pad_oe == $past(bus_wdata[PINS-1:0])); // R2

    AST_LEVEL_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == LEVEL_MASK && bus_wdata[2*PINS-1:PINS] == '0)
        |=> $stable(pad_out)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && bus_we) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pin_mode))); // R7

    AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> bus_rvalid); // R5

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_we) |=> !bus_rvalid); // R5

    AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> bus_rdata[2*PINS-1:PINS] == '0); // R5

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> bus_rdata == '0); // R5

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        pin_in_sync == $past(pad_in, SYNC_STAGES)); // R8

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .PINS       (PINS),
    .ADDR_W     (ADDR_W),
    .MASK_OFS   (MASK_OFS),
    .PORT_IDX   (PORT_IDX),
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pin_mode   (pin_mode),
    .pin_in_sync(pin_in_sync)
);

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;
    localparam int PINS = 8;
    localparam int AW   = 12;
    localparam int MOFS = 'h80;
    localparam int PORT = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_req = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic            bus_rvalid;
    logic [7:0]      pad_in = '0;
    logic [7:0]      pad_out;
    logic [7:0]      pad_oe;
    logic [7:0]      pin_mode;
    logic [7:0]      pin_in_sync;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit armed = 0;

    // reference state
    logic [7:0]  m_reg [3];
    logic [7:0]  m_s1, m_s2;
    logic [15:0] m_rdata;
    logic        m_rv;

    always #2.5 clk = ~clk;

    gpio_port_regs #(
        .PINS(PINS), .ADDR_W(AW), .MASK_OFS(MOFS), .PORT_IDX(PORT), .SYNC_STAGES(2)
    ) i_gpio_port_regs (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pin_mode(pin_mode), .pin_in_sync(pin_in_sync)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // group index of an address for this port, -1 if unmapped
    function automatic int map_addr(int a, output bit msk);
        msk = 0;
        for (int g = 0; g < 4; g++) begin
            if (a == g * 16 + PORT * 4) return g;
            if (g < 3 && a == MOFS + g * 16 + PORT * 4) begin
                msk = 1;
                return g;
            end
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int i = 0; i < 3; i++) m_reg[i] = '0;
            m_rdata = '0;
            m_rv    = 0;
        end else begin
            bit msk;
            int g;
            g = map_addr(int'(bus_addr), msk);
            if (bus_req && !bus_we) begin
                m_rv = 1;
                if (g == 3)      m_rdata = {8'h00, m_s2};
                else if (g >= 0) m_rdata = {8'h00, m_reg[g]};
                else             m_rdata = '0;
            end else begin
                m_rv    = 0;
                m_rdata = '0;
            end
            if (bus_req && bus_we && g >= 0 && g < 3) begin
                if (msk)
                    m_reg[g] = (m_reg[g] & ~bus_wdata[15:8]) | (bus_wdata[7:0] & bus_wdata[15:8]);
                else
                    m_reg[g] = bus_wdata[7:0];
            end
        end
        m_s2 = m_s1;
        m_s1 = pad_in;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL R5 watchdog actual=%0d expected<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (armed && !rst) begin
            check("R2 pin_mode", {8'h0, pin_mode}, {8'h0, m_reg[0]});
            check("R4 pad_oe", {8'h0, pad_oe}, {8'h0, m_reg[1]});
            check("R4 pad_out", {8'h0, pad_out}, {8'h0, m_reg[2]});
            check("R8 pin_in_sync", {8'h0, pin_in_sync}, {8'h0, m_s2});
            check("R5 rvalid", {15'h0, bus_rvalid}, {15'h0, m_rv});
            check("R5 rdata", bus_rdata, m_rdata);
        end
    end

    task automatic wr(int a, logic [15:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic rd(int a, output logic [15:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = AW'(a);
        @(negedge clk);
        check("R5 rvalid directed", {15'h0, bus_rvalid}, 16'h1);
        d = bus_rdata;
        bus_req = 0;
    endtask

    localparam int MODE_P = 'h08, DIR_P = 'h18, LVL_P = 'h28, PAD_P = 'h38;
    localparam int MODE_M = 'h88, DIR_M = 'h98, LVL_M = 'hA8, PAD_M = 'hB8;

    initial begin
        logic [15:0] r;
        int pool [14];
        pool = '{'h08, 'h18, 'h28, 'h38, 'h88, 'h98, 'hA8, 'hB8,
                 'h0C, 'h19, 'h1C, 'h48, 'h00, 'hC8};

        repeat (3) @(negedge clk);
        // R1: state while in reset
        check("R1 pad_oe", {8'h0, pad_oe}, 16'h0);
        check("R1 pad_out", {8'h0, pad_out}, 16'h0);
        check("R1 pin_mode", {8'h0, pin_mode}, 16'h0);
        check("R1 rvalid", {15'h0, bus_rvalid}, 16'h0);
        @(negedge clk);
        rst = 0;
        armed = 1;

        wr(DIR_P, 16'hFFA5);
        check("R2 plain load", {8'h0, pad_oe}, 16'h00A5);
        wr(DIR_M, 16'h0F03);
        check("R3 masked merge", {8'h0, pad_oe}, 16'h00A3);
        wr(DIR_M, 16'h00FF);
        check("R3 zero strobe", {8'h0, pad_oe}, 16'h00A3);
        wr(LVL_P, 16'h003C);
        check("R4 drive level", {8'h0, pad_out}, 16'h003C);
        wr(LVL_M, 16'h8180);
        check("R3 level merge", {8'h0, pad_out}, 16'h00BC);
        wr(MODE_P, 16'h0011);
        wr(MODE_M, 16'h0202);
        check("R3 mode merge", {8'h0, pin_mode}, 16'h0013);

        rd(DIR_P, r);  check("R5 plain read", r, 16'h00A3);
        rd(DIR_M, r);  check("R5 alias read", r, 16'h00A3);
        rd(LVL_M, r);  check("R5 level read", r, 16'h00BC);

        @(negedge clk);
        pad_in = 8'h5C;
        @(negedge clk);
        check("R8 one edge", {8'h0, pin_in_sync}, 16'h0000);
        @(negedge clk);
        check("R8 two edges", {8'h0, pin_in_sync}, 16'h005C);
        rd(PAD_P, r);  check("R6 pad read", r, 16'h005C);

        wr(PAD_P, 16'hFFFF);
        check("R6 pad write oe", {8'h0, pad_oe}, 16'h00A3);
        check("R6 pad write out", {8'h0, pad_out}, 16'h00BC);
        rd(PAD_P, r);  check("R6 pad after write", r, 16'h005C);
        wr(PAD_M, 16'hFFFF);
        check("R7 masked pad write", {8'h0, pin_mode}, 16'h0013);
        rd(PAD_M, r);  check("R7 masked pad read", r, 16'h0000);
        wr('h1C, 16'h00FF);
        check("R7 foreign slot", {8'h0, pad_oe}, 16'h00A3);
        rd('h1C, r);   check("R7 foreign read", r, 16'h0000);
        wr('h19, 16'h0000);
        check("R7 unaligned", {8'h0, pad_oe}, 16'h00A3);
        rd('h48, r);   check("R7 beyond window", r, 16'h0000);

        // random traffic, compared every cycle by the reference
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            bus_req   = ($urandom % 3) != 0;
            bus_we    = $urandom % 2;
            bus_addr  = AW'(pool[$urandom % 14]);
            bus_wdata = 16'($urandom);
            if (($urandom % 4) == 0) bus_wdata[15:8] = 8'h00;
            pad_in    = 8'($urandom);
        end
        @(negedge clk);
        bus_req = 0;
        repeat (4) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule